// File: doc/BRIEF.md
# NOR Flash Program/Erase Polling Controller

This block is a bus master that runs the write-side protocol of an asynchronous NOR flash device built from one to four byte-wide lanes. A host asks for one of three operations: program one word, erase the whole device, or erase a set of sectors. The controller then issues the matching unlock-prefixed command writes. For a multi-sector erase it appends the extra sector commands and confirms after each one that the erase window is still open. It then polls the device until the embedded algorithm finishes. The result is reported as a one-cycle done pulse together with a fail flag.

Completion is checked by one of two methods, chosen per request. The first compares the polling bit with the expected bit. The second watches for the toggle bit to stop changing. Both treat the device's time-limit bit as a hint to look once more before declaring failure. Every failure, including a poll-count overrun, is followed by the three-write reset sequence. The strobes use fixed setup, pulse and hold lengths given in clock cycles.

Top module: `flash_poll_ctrl`

## Requirements
- R1: Operation 0 (program) issues exactly four writes: rep(AAh)@5555h, rep(55h)@2AAAh, rep(A0h)@5555h, then the request data at full width to the request address. rep(b) is b copied onto every byte lane.
- R2: Operation 1 (chip erase) issues six writes: rep(AAh)@5555h, rep(55h)@2AAAh, rep(80h)@5555h, rep(AAh)@5555h, rep(55h)@2AAAh, rep(10h)@5555h. Polling then reads the request address with an expected bit 7 of 1.
- R3: Operation 2 (sector erase) takes a sector mask. The lowest set sector s is the target of the sixth write, rep(30h) at address s<<14, and is also the poll address. Every further set sector, in ascending order, gets a status read, a rep(30h) write to its base address, and another status read. If bit 3 of any lane is 1 on either read, the request fails.
- R4: Each bus access holds the address for SETUP cycles, raises exactly one strobe (write or read) for PULSE cycles, then holds the address for HOLD cycles. The two strobes are never high together, and the address is stable while a strobe is high.
- R5: Data-poll method (check select 0): a read passes when bit 8k+7 of every lane k equals the expected bit. For a program the expected bit is bit 8k+7 of the data; for an erase it is 1. A mismatch on any single lane does not pass.
- R6: Data-poll method: if a read does not pass and any lane shows bit 8k+5 = 1, exactly one more read is made. The request passes if that read passes and fails otherwise.
- R7: Toggle method (check select 1): reads are taken in pairs. A pair in which no lane's bit 8k+6 differs passes.
- R8: Toggle method: if a pair toggles and the second read shows any lane with bit 8k+5 = 1, one more pair is read. The request fails if that pair still toggles and passes if it does not.
- R9: After POLL_LIMIT consecutive unsuccessful poll rounds with no time-limit bit, the request fails. A round is one read, or one pair in toggle mode.
- R10: Every failure after bus activity has begun is followed by rep(AAh)@5555h, rep(55h)@2AAAh, rep(F0h)@5555h before done.
- R11: Operation 3, or a sector erase with an empty mask, completes with fail = 1 and no bus access at all.
- R12: req_ready_o is high only when idle. A request is taken on req_valid_i && req_ready_o, requests seen while busy have no effect, and done_o is a single-cycle pulse with fail_o valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_op_i | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 invalid |
| req_chk_i | input | 1 | 0 data-poll check, 1 toggle check |
| req_addr_i | input | AW | Program or poll address |
| req_data_i | input | 8*LANES | Program data |
| req_sect_i | input | NSECT | Sector mask for sector erase |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Failure flag, valid with done_o |
| mem_addr_o | output | AW | Flash address |
| mem_wdata_o | output | 8*LANES | Flash write data |
| mem_we_o | output | 1 | Write strobe, active high |
| mem_oe_o | output | 1 | Read strobe, active high |
| mem_rdata_i | input | 8*LANES | Flash read data |

## Verification
The bench replays scripted status words to the controller, one word per read. Each script targets one branch: an immediate match, a match after several busy reads, or a single lane out of step, which separates an all-lanes check from an any-lane check. Other scripts raise the time-limit bit and then either recover or stay busy, which separates the recheck path from immediate failure. A script that never completes shows the poll limit at work. Toggle scripts likewise separate a settled pair, a toggling pair without the time-limit bit, and a toggling pair with it. Sector scripts use masks with gaps and raise bit 3 on the post-write read, which shows the ordering of the extra sectors and the window check. The full write log is compared word for word with the expected command sequences.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_CHIP = 2'd1, OP_SECT = 2'd2, OP_NONE = 2'd3} op_e;
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_XPRE, S_XWR, S_XPOST, S_POLL, S_RST, S_END} ctrl_st_e;
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD} bus_st_e;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam int unsigned UNL_ADDR_A = 32'h5555;
  localparam int unsigned UNL_ADDR_B = 32'h2AAA;
endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if import flash_poll_pkg::*; #(
  parameter int unsigned AW    = 17,
  parameter int unsigned DW    = 32,
  parameter int unsigned SETUP = 1,
  parameter int unsigned PULSE = 2,
  parameter int unsigned HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_oe_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned MAXPH = (SETUP > PULSE) ? ((SETUP > HOLD) ? SETUP : HOLD)
                                                  : ((PULSE > HOLD) ? PULSE : HOLD);
  localparam int unsigned CW = $clog2(MAXPH + 1);

  bus_st_e        st_q;
  logic [CW-1:0]  cnt_q;
  logic           wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= B_IDLE;
      cnt_q       <= '0;
      wr_q        <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      mem_oe_o    <= 1'b0;
      rdata_o     <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        B_IDLE: if (start_i) begin
          mem_addr_o  <= addr_i;
          mem_wdata_o <= wdata_i;
          wr_q        <= wr_i;
          cnt_q       <= '0;
          st_q        <= B_SETUP;
        end
        B_SETUP: if (cnt_q == CW'(SETUP - 1)) begin
          cnt_q    <= '0;
          st_q     <= B_PULSE;
          mem_we_o <= wr_q;
          mem_oe_o <= !wr_q;
        end else cnt_q <= cnt_q + 1'b1;
        B_PULSE: if (cnt_q == CW'(PULSE - 1)) begin
          cnt_q    <= '0;
          st_q     <= B_HOLD;
          mem_we_o <= 1'b0;
          mem_oe_o <= 1'b0;
          if (!wr_q) rdata_o <= mem_rdata_i;
        end else cnt_q <= cnt_q + 1'b1;
        B_HOLD: if (cnt_q == CW'(HOLD - 1)) begin
          cnt_q  <= '0;
          st_q   <= B_IDLE;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != B_IDLE);

  p_excl_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_oe_o));
  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_oe_o) && $past(mem_we_o || mem_oe_o) |-> $stable(mem_addr_o));
  p_start_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == B_IDLE));
endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] cur_i,
  input  logic [8*LANES-1:0] prev_i,
  input  logic [LANES-1:0]   exp7_i,
  output logic               dq7_ok_o,
  output logic               tog_o,
  output logic               tmo_o,
  output logic               win_o
);
  logic [LANES-1:0] l_ok, l_tog, l_tmo, l_win;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign l_ok[l]  = (cur_i[8*l+7] == exp7_i[l]);
    assign l_tog[l] = cur_i[8*l+6] ^ prev_i[8*l+6];
    assign l_tmo[l] = cur_i[8*l+5];
    assign l_win[l] = cur_i[8*l+3];
  end

  assign dq7_ok_o = &l_ok;
  assign tog_o    = |l_tog;
  assign tmo_o    = |l_tmo;
  assign win_o    = |l_win;
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl import flash_poll_pkg::*; #(
  parameter int unsigned AW         = 17,
  parameter int unsigned LANES      = 4,
  parameter int unsigned NSECT      = 8,
  parameter int unsigned SECT_SHIFT = 14,
  parameter int unsigned SETUP      = 1,
  parameter int unsigned PULSE      = 2,
  parameter int unsigned HOLD       = 1,
  parameter int unsigned POLL_LIMIT = 4096
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [1:0]            req_op_i,
  input  logic                  req_chk_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [8*LANES-1:0]    req_data_i,
  input  logic [NSECT-1:0]      req_sect_i,
  output logic                  done_o,
  output logic                  fail_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [8*LANES-1:0]    mem_wdata_o,
  output logic                  mem_we_o,
  output logic                  mem_oe_o,
  input  logic [8*LANES-1:0]    mem_rdata_i
);
  localparam int unsigned DW   = 8 * LANES;
  localparam int unsigned SW   = $clog2(NSECT);
  localparam int unsigned CNTW = $clog2(POLL_LIMIT + 1);

  function automatic logic [SW-1:0] low_idx(input logic [NSECT-1:0] m);
    low_idx = '0;
    for (int i = NSECT - 1; i >= 0; i--) if (m[i]) low_idx = SW'(i);
  endfunction

  function automatic logic [AW-1:0] sect_base(input logic [SW-1:0] idx);
    sect_base = '0;
    sect_base[SECT_SHIFT +: SW] = idx;
  endfunction

  ctrl_st_e         st_q;
  op_e              op_q;
  logic             chk_q, issued_q, phase_q, pair_q, fail_q;
  logic [2:0]       step_q, last_step;
  logic [AW-1:0]    addr_q, poll_addr_q, cmd_addr;
  logic [DW-1:0]    data_q, prev_q, cmd_data;
  logic [NSECT-1:0] mask_q;
  logic [LANES-1:0] exp7_q, exp7_in;
  logic [CNTW-1:0]  cnt_q;

  logic             bus_start, bus_wr, bus_busy, bus_done;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata, bus_rdata;
  logic             dq7_ok, tog, tmo, win;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      exp7_in[l] = (req_op_i == OP_PROG) ? req_data_i[8*l+7] : 1'b1;
  end

  // command word for the current step of a sequence
  always_comb begin
    cmd_addr = AW'(UNL_ADDR_A);
    cmd_data = {LANES{CMD_UNL1}};
    unique case (step_q)
      3'd1: begin cmd_addr = AW'(UNL_ADDR_B); cmd_data = {LANES{CMD_UNL2}}; end
      3'd2: cmd_data = {LANES{(st_q == S_RST) ? CMD_RESET :
                              (op_q == OP_PROG) ? CMD_PROG : CMD_ERASE}};
      3'd3: if (op_q == OP_PROG) begin cmd_addr = addr_q; cmd_data = data_q; end
      3'd4: begin cmd_addr = AW'(UNL_ADDR_B); cmd_data = {LANES{CMD_UNL2}}; end
      3'd5: if (op_q == OP_CHIP) cmd_data = {LANES{CMD_CHIP}};
            else begin cmd_addr = poll_addr_q; cmd_data = {LANES{CMD_SECT}}; end
      default: ;
    endcase
  end

  assign last_step = (st_q == S_RST) ? 3'd2 : (op_q == OP_PROG) ? 3'd3 : 3'd5;

  always_comb begin
    bus_start = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = cmd_addr;
    bus_wdata = cmd_data;
    if (!issued_q) begin
      unique case (st_q)
        S_CMD, S_RST: begin bus_start = 1'b1; bus_wr = 1'b1; end
        S_XPRE, S_XPOST, S_POLL: begin bus_start = 1'b1; bus_addr = poll_addr_q; end
        S_XWR: begin
          bus_start = 1'b1;
          bus_wr    = 1'b1;
          bus_addr  = sect_base(low_idx(mask_q));
          bus_wdata = {LANES{CMD_SECT}};
        end
        default: ;
      endcase
    end
  end

  flash_bus_if #(.AW(AW), .DW(DW), .SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD)) u_bus (
    .clk_i, .rst_ni,
    .start_i(bus_start), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .busy_o(bus_busy), .done_o(bus_done), .rdata_o(bus_rdata),
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_oe_o, .mem_rdata_i
  );

  flash_status_eval #(.LANES(LANES)) u_eval (
    .cur_i(bus_rdata), .prev_i(prev_q), .exp7_i(exp7_q),
    .dq7_ok_o(dq7_ok), .tog_o(tog), .tmo_o(tmo), .win_o(win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;      op_q <= OP_PROG;     chk_q <= 1'b0;
      issued_q <= 1'b0;    phase_q <= 1'b0;     pair_q <= 1'b0;
      fail_q <= 1'b0;      step_q <= '0;        addr_q <= '0;
      poll_addr_q <= '0;   data_q <= '0;        prev_q <= '0;
      mask_q <= '0;        exp7_q <= '0;        cnt_q <= '0;
    end else begin
      if (bus_start) issued_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          chk_q   <= req_chk_i;
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          exp7_q  <= exp7_in;
          step_q  <= '0;
          phase_q <= 1'b0;
          pair_q  <= 1'b0;
          cnt_q   <= '0;
          mask_q  <= req_sect_i & (req_sect_i - NSECT'(1));
          poll_addr_q <= (req_op_i == OP_SECT) ? sect_base(low_idx(req_sect_i)) : req_addr_i;
          if (req_op_i == OP_NONE || (req_op_i == OP_SECT && req_sect_i == '0)) begin
            fail_q <= 1'b1;
            st_q   <= S_END;
          end else begin
            fail_q <= 1'b0;
            st_q   <= S_CMD;
          end
        end
        S_CMD: if (bus_done) begin
          issued_q <= 1'b0;
          if (step_q == last_step) begin
            step_q <= '0;
            st_q   <= (op_q == OP_SECT && mask_q != '0) ? S_XPRE : S_POLL;
          end else step_q <= step_q + 3'd1;
        end
        S_XPRE: if (bus_done) begin
          issued_q <= 1'b0;
          if (win) begin fail_q <= 1'b1; step_q <= '0; st_q <= S_RST; end
          else st_q <= S_XWR;
        end
        S_XWR: if (bus_done) begin
          issued_q <= 1'b0;
          mask_q   <= mask_q & (mask_q - NSECT'(1));
          st_q     <= S_XPOST;
        end
        S_XPOST: if (bus_done) begin
          issued_q <= 1'b0;
          if (win) begin fail_q <= 1'b1; step_q <= '0; st_q <= S_RST; end
          else st_q <= (mask_q != '0) ? S_XPRE : S_POLL;
        end
        S_POLL: if (bus_done) begin
          issued_q <= 1'b0;
          if (!chk_q) begin
            if (dq7_ok) st_q <= S_END;
            else if (phase_q) begin fail_q <= 1'b1; step_q <= '0; st_q <= S_RST; end
            else if (tmo) phase_q <= 1'b1;
            else if (cnt_q == CNTW'(POLL_LIMIT - 1)) begin
              fail_q <= 1'b1; step_q <= '0; st_q <= S_RST;
            end else cnt_q <= cnt_q + 1'b1;
          end else if (!pair_q) begin
            prev_q <= bus_rdata;
            pair_q <= 1'b1;
          end else begin
            pair_q <= 1'b0;
            if (!tog) st_q <= S_END;
            else if (phase_q) begin fail_q <= 1'b1; step_q <= '0; st_q <= S_RST; end
            else if (tmo) phase_q <= 1'b1;
            else if (cnt_q == CNTW'(POLL_LIMIT - 1)) begin
              fail_q <= 1'b1; step_q <= '0; st_q <= S_RST;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RST: if (bus_done) begin
          issued_q <= 1'b0;
          if (step_q == last_step) st_q <= S_END;
          else step_q <= step_q + 3'd1;
        end
        S_END: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign done_o      = (st_q == S_END);
  assign fail_o      = fail_q;

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_busy && !mem_we_o && !mem_oe_o);
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNTW'(POLL_LIMIT));
  p_rst_failed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RST) |-> fail_o);
endmodule

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
  localparam int AW = 17, LANES = 4, DW = 32, NSECT = 8, LIMIT = 5, PULSE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 1'b0, req_ready, req_chk = 1'b0;
  logic [1:0]       req_op = 2'd0;
  logic [AW-1:0]    req_addr = '0;
  logic [DW-1:0]    req_data = '0;
  logic [NSECT-1:0] req_sect = '0;
  logic             done, fail;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata, mem_rdata;
  logic             mem_we, mem_oe;

  logic [DW-1:0] resp [16];
  logic [AW-1:0] wa [32];
  logic [DW-1:0] wd [32];
  logic [AW-1:0] ra;
  int rn = 0, wn = 0, bad_pulse = 0, run_len = 0, n_chk = 0, n_fail = 0;
  logic got_fail;

  assign mem_rdata = resp[(rn < 16) ? rn : 15];

  flash_poll_ctrl #(.POLL_LIMIT(LIMIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_chk_i(req_chk), .req_addr_i(req_addr), .req_data_i(req_data),
    .req_sect_i(req_sect), .done_o(done), .fail_o(fail), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_oe_o(mem_oe), .mem_rdata_i(mem_rdata)
  );

  always @(negedge mem_we) if (rst_n) begin
    if (wn < 32) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
    wn++;
  end
  always @(negedge mem_oe) if (rst_n) begin ra = mem_addr; rn++; end
  always @(negedge clk) begin
    if (mem_we || mem_oe) run_len++;
    else begin
      if (run_len != 0 && run_len != PULSE) bad_pulse++;
      run_len = 0;
    end
  end

  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    return {LANES{b}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic chk_w(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    chk(wa[i] == a && wd[i] == d, tag, {15'd0, wa[i], wd[i]}, {15'd0, a, d});
  endtask

  task automatic chk_unlock(input int b, input string tag);
    chk_w(b, 17'h05555, rep(8'hAA), tag);
    chk_w(b + 1, 17'h02AAA, rep(8'h55), tag);
  endtask

  task automatic chk_reset(input int b);
    chk_unlock(b, "R10 reset unlock");
    chk_w(b + 2, 17'h05555, rep(8'hF0), "R10 reset command");
  endtask

  task automatic clear_log();
    rn = 0; wn = 0;
    for (int i = 0; i < 16; i++) resp[i] = '0;
  endtask

  task automatic start_op(input logic [1:0] op, input logic c, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [NSECT-1:0] s);
    @(negedge clk);
    req_op = op; req_chk = c; req_addr = a; req_data = d; req_sect = s;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    got_fail = fail;
    if (k >= 3000) chk(1'b0, "R12 done timeout", 64'(k), 64'd0);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic c, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NSECT-1:0] s);
    start_op(op, c, a, d, s);
    wait_done();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog expired actual=1 expected=0");
    finish_run();
  end

  localparam logic [AW-1:0] A = 17'h01234;
  localparam logic [DW-1:0] D = 32'h8001_7F80;
  logic [DW-1:0] busy;

  initial begin
    busy = (D ^ 32'h80808080) & ~32'h20202020;
    for (int i = 0; i < 16; i++) resp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R12 reset state", {60'd0, req_ready, done, mem_we, mem_oe}, 64'b1000);

    // program, data poll, immediate pass
    clear_log(); resp[0] = D;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R5 immediate pass", got_fail, 0);
    chk_eq("R1 write count", wn, 4);
    chk_unlock(0, "R1 unlock");
    chk_w(2, 17'h05555, rep(8'hA0), "R1 program command");
    chk_w(3, A, D, "R1 program data full width");
    chk_eq("R5 poll reads", rn, 1);
    chk_eq("R5 poll address", ra, A);

    // busy twice then match
    clear_log(); resp[0] = busy; resp[1] = busy; resp[2] = D;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R5 pass after busy", got_fail, 0);
    chk_eq("R5 reads after busy", rn, 3);

    // time-limit bit then recovery
    clear_log(); resp[0] = busy | 32'h00200000; resp[1] = D; resp[2] = busy;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R6 recheck pass", got_fail, 0);
    chk_eq("R6 recheck reads", rn, 2);

    // time-limit bit then still wrong
    clear_log(); resp[0] = busy | 32'h00200000; resp[1] = busy; resp[2] = D;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R6 recheck fail", got_fail, 1);
    chk_eq("R6 recheck fail reads", rn, 2);
    chk_eq("R10 writes with reset", wn, 7);
    chk_reset(4);

    // single lane wrong
    clear_log(); resp[0] = D ^ 32'h00800000; resp[1] = D;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R5 one lane mismatch no pass", rn, 2);
    chk_eq("R5 one lane mismatch result", got_fail, 0);

    // never completes
    clear_log(); for (int i = 0; i < 16; i++) resp[i] = busy;
    run_op(2'd0, 1'b0, A, D, '0);
    chk_eq("R9 limit fail", got_fail, 1);
    chk_eq("R9 limit reads", rn, LIMIT);
    chk_eq("R10 limit writes", wn, 7);
    chk_reset(4);

    // chip erase, data poll
    clear_log(); resp[0] = 32'h0; resp[1] = 32'hFFFF_FFFF;
    run_op(2'd1, 1'b0, 17'h1ABCD, '0, '0);
    chk_eq("R2 write count", wn, 6);
    chk_unlock(0, "R2 first unlock");
    chk_w(2, 17'h05555, rep(8'h80), "R2 setup command");
    chk_unlock(3, "R2 second unlock");
    chk_w(5, 17'h05555, rep(8'h10), "R2 chip command");
    chk_eq("R2 pass", got_fail, 0);
    chk_eq("R2 reads", rn, 2);
    chk_eq("R2 poll address", ra, 17'h1ABCD);

    // toggle: settled at once
    clear_log(); resp[0] = 32'h40404040; resp[1] = 32'h40404040;
    run_op(2'd1, 1'b1, 17'h00010, '0, '0);
    chk_eq("R7 settled pass", got_fail, 0);
    chk_eq("R7 settled reads", rn, 2);

    // toggle: first pair toggles, second settled
    clear_log(); resp[0] = 32'h40404040;
    run_op(2'd1, 1'b1, 17'h00010, '0, '0);
    chk_eq("R7 second pair pass", got_fail, 0);
    chk_eq("R7 second pair reads", rn, 4);

    // toggle with time-limit bit, still toggling
    clear_log(); resp[0] = 32'h40; resp[1] = 32'h20; resp[2] = 32'h40; resp[3] = 32'h0;
    run_op(2'd1, 1'b1, 17'h00010, '0, '0);
    chk_eq("R8 toggle fail", got_fail, 1);
    chk_eq("R8 toggle fail reads", rn, 4);
    chk_eq("R10 toggle fail writes", wn, 9);
    chk_reset(6);

    // toggle with time-limit bit, then stops
    clear_log(); resp[0] = 32'h40; resp[1] = 32'h20; resp[2] = 32'h20; resp[3] = 32'h20;
    run_op(2'd1, 1'b1, 17'h00010, '0, '0);
    chk_eq("R8 toggle recover", got_fail, 0);
    chk_eq("R8 toggle recover reads", rn, 4);

    // sector erase, sectors 2 and 5
    clear_log(); resp[2] = 32'hFFFF_FFFF;
    run_op(2'd2, 1'b0, '0, '0, 8'b0010_0100);
    chk_eq("R3 writes", wn, 7);
    chk_w(5, 17'h08000, rep(8'h30), "R3 first sector");
    chk_w(6, 17'h14000, rep(8'h30), "R3 extra sector");
    chk_eq("R3 reads", rn, 3);
    chk_eq("R3 pass", got_fail, 0);
    chk_eq("R3 poll address", ra, 17'h08000);

    // sector erase, window closed after extra write
    clear_log(); resp[1] = 32'h00000008;
    run_op(2'd2, 1'b0, '0, '0, 8'b0000_0011);
    chk_eq("R3 window fail", got_fail, 1);
    chk_w(5, 17'h00000, rep(8'h30), "R3 sector 0");
    chk_w(6, 17'h04000, rep(8'h30), "R3 sector 1");
    chk_eq("R3 window reads", rn, 2);
    chk_eq("R10 window writes", wn, 10);
    chk_reset(7);

    // invalid requests
    clear_log();
    run_op(2'd2, 1'b0, '0, '0, '0);
    chk_eq("R11 empty mask fail", got_fail, 1);
    chk_eq("R11 empty mask bus", wn + rn, 0);
    run_op(2'd3, 1'b0, A, D, 8'hFF);
    chk_eq("R11 op 3 fail", got_fail, 1);
    chk_eq("R11 op 3 bus", wn + rn, 0);

    // request while busy
    clear_log(); resp[0] = busy; resp[1] = busy; resp[2] = D;
    start_op(2'd0, 1'b0, A, D, '0);
    repeat (5) @(negedge clk);
    chk_eq("R12 ready low when busy", req_ready, 0);
    req_op = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk_eq("R12 busy request ignored writes", wn, 4);
    chk_eq("R12 busy request ignored reads", rn, 3);
    chk_eq("R12 original completes", got_fail, 0);
    repeat (20) @(negedge clk);
    chk_eq("R12 nothing after done", wn, 4);

    chk_eq("R4 strobe widths", bad_pulse, 0);
    finish_run();
  end
endmodule